// File: doc/BRIEF.md
# Codec Control Serial Write Engine

This block takes register write requests for a pair of audio codecs and shifts each one out over a three-wire control bus: a serial clock, a serial data line and two active-low chip selects. A direct write carries a chip index, a 5-bit register address and a data byte, and produces one frame. A masked broadcast keeps a shadow copy of every codec register. For each chip in turn it clears the masked bits of the shadow value, merges in the new bits, updates the shadow and sends the merged byte to that chip. A rate request turns a sample rate in Hz into the codec speed-mode bits, then runs a masked broadcast to the speed register.

Each frame is 16 bits long. It opens with a fixed device code and a write flag, and it is framed by a chip select. Every step of the bus sequence lasts `STEP_CYCLES` clock cycles. The host side uses a valid/ready handshake, and `busy` stays high from the cycle after a request is accepted until the last frame of that request has ended.

The control FSM has the states CT_IDLE, CT_LAUNCH and CT_WAIT, with these transitions:
- CT_IDLE to CT_LAUNCH when a request that produces frames is accepted.
- CT_LAUNCH to CT_WAIT after one cycle.
- CT_WAIT back to CT_LAUNCH when a frame ends and a broadcast still has a chip to serve.
- CT_WAIT to CT_IDLE when a frame ends and no chip remains.

The shift FSM has the states SH_IDLE, SH_PRE (lines released), SH_SEL (select low), SH_CLKLO, SH_DATA, SH_CLKHI and SH_END (all lines released). SH_CLKHI returns to SH_CLKLO while bits remain, and goes on to SH_END after the sixteenth bit. Every other state moves to the next state in the order listed.

Top module: `cwe_codec_ctl`

## Requirements
- R1: After reset and whenever the engine is idle, `cs_n`, `sclk` and `sdout` are all high, `req_ready` is 1 and `busy` is 0.
- R2: A frame is 16 bits, sampled on the rising edges of `sclk`, most significant bit first. From the top down it holds the device code 2'b10, a 1, the 5-bit register address and the 8-bit data.
- R3: `req_op`=0 is a direct write. A chip index of 0 pulls `cs_n[0]` low. An index of 1, 2 or 3 pulls `cs_n[1]` low. An index of 4 to 7 is accepted and sends no frame. `req_op`=3 is accepted and ignored.
- R4: For each bit, `sclk` falls, then `sdout` takes the bit, then `sclk` rises. `sdout` never changes while `sclk` is high inside a frame.
- R5: After the sixteenth bit, the chip select and `sdout` return high together. Every bus step lasts `STEP_CYCLES` cycles, so a chip select stays low for exactly 49×`STEP_CYCLES` cycles.
- R6: `req_op`=1 is a masked broadcast. It sends (shadow AND NOT `req_mask`) OR `req_data` to chip 0 and then to chip 1 at `req_addr`, and stores each result in that chip's shadow.
- R7: A direct write stores its data byte in the shadow of the chip it selected. All shadow values reset to 0.
- R8: `req_op`=2 maps `req_rate` to a masked broadcast at register 2 with mask 0x0F. The value is 0x0A above 108000, 0x05 above 54000, and 0x00 otherwise.
- R9: A rate request of 0 is accepted and sends nothing.
- R10: `req_ready` is low and `busy` is high from the cycle after acceptance until the final release. Requests offered during that time are not taken.
- R11: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_op | input | 2 | 0 direct write, 1 masked broadcast, 2 rate, 3 ignored |
| req_chip | input | 3 | Chip index for a direct write |
| req_addr | input | 5 | Register address |
| req_data | input | 8 | Data byte, or OR value for a broadcast |
| req_mask | input | 8 | Bits replaced by a broadcast |
| req_rate | input | 18 | Sample rate in Hz for a rate request |
| busy | output | 1 | A request is in progress |
| cs_n | output | 2 | Active-low chip selects, bit 0 for chip 0 |
| sclk | output | 1 | Serial clock |
| sdout | output | 1 | Serial data |

## Verification
Random direct writes spread over all eight chip indices tell apart the cs_n[0] path, the cs_n[1] path and the rejected path. Because they also seed the shadow, the broadcasts that follow show whether the read-modify-write merges in the stored value or only the requested bits. A broadcast with mask 0 and value 0 sends both shadows back unchanged. Rates placed on and one above the 54000 and 108000 thresholds, together with a rate of 0, separate the three speed codes from the no-write case. Offering a request while a frame is running shows whether the handshake really holds it off.

// File: rtl/cwe_pkg.sv
package cwe_pkg;
    localparam int CHIPS    = 2;
    localparam int CHIP_W   = $clog2(CHIPS);
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 5;
    localparam logic [1:0] DEV_CODE = 2'b10;
    localparam logic [ADDR_W-1:0] SPEED_REG  = 5'h02;
    localparam logic [7:0]        SPEED_MASK = 8'h0F;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_BCAST = 2'd1,
        OP_RATE  = 2'd2,
        OP_NONE  = 2'd3
    } cwe_op_e;

    typedef enum logic [2:0] {
        SH_IDLE, SH_PRE, SH_SEL, SH_CLKLO, SH_DATA, SH_CLKHI, SH_END
    } shift_state_e;

    typedef enum logic [1:0] {
        CT_IDLE, CT_LAUNCH, CT_WAIT
    } ctl_state_e;

    function automatic logic [FRAME_W-1:0] build_frame(input logic [ADDR_W-1:0] a,
                                                       input logic [7:0] d);
        return {DEV_CODE, 1'b1, a, d};
    endfunction
endpackage

// File: rtl/cwe_rate_map.sv
module cwe_rate_map #(
    parameter int RATE_W  = 18,
    parameter int QUAD_HZ = 108000,
    parameter int DUAL_HZ = 54000
) (
    input  logic [RATE_W-1:0] rate,
    output logic [7:0]        speed_bits,
    output logic              rate_valid
);
    always_comb begin
        rate_valid = (rate != '0);
        if (rate > RATE_W'(QUAD_HZ))
            speed_bits = 8'h0A;
        else if (rate > RATE_W'(DUAL_HZ))
            speed_bits = 8'h05;
        else
            speed_bits = 8'h00;
    end
endmodule

// File: rtl/cwe_shifter.sv
module cwe_shifter
    import cwe_pkg::*;
#(
    parameter int STEP_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               chip_sel,
    input  logic [FRAME_W-1:0] frame,
    output logic               done,
    output logic [1:0]         cs_n,
    output logic               sclk,
    output logic               sdout
);
    localparam int CNT_W = (STEP_CYCLES < 2) ? 1 : $clog2(STEP_CYCLES);
    localparam int BIT_W = $clog2(FRAME_W);

    shift_state_e        state, nstate;
    logic [CNT_W-1:0]    cnt;
    logic [BIT_W-1:0]    bit_idx;
    logic [FRAME_W-1:0]  frame_q;
    logic                sel_q;
    logic                dat_q;
    logic                step_end;

    assign step_end = (cnt == '0);

    always_comb begin
        nstate = state;
        unique case (state)
            SH_IDLE:  if (start)    nstate = SH_PRE;
            SH_PRE:   if (step_end) nstate = SH_SEL;
            SH_SEL:   if (step_end) nstate = SH_CLKLO;
            SH_CLKLO: if (step_end) nstate = SH_DATA;
            SH_DATA:  if (step_end) nstate = SH_CLKHI;
            SH_CLKHI: if (step_end) nstate = (bit_idx == '0) ? SH_END : SH_CLKLO;
            SH_END:   if (step_end) nstate = SH_IDLE;
            default:  nstate = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            frame_q <= '0;
            sel_q   <= 1'b0;
            dat_q   <= 1'b1;
        end else begin
            state <= nstate;
            if (state == SH_IDLE) begin
                if (start) begin
                    cnt     <= CNT_W'(STEP_CYCLES - 1);
                    bit_idx <= BIT_W'(FRAME_W - 1);
                    frame_q <= frame;
                    sel_q   <= chip_sel;
                    dat_q   <= 1'b1;
                end
            end else if (step_end) begin
                cnt <= CNT_W'(STEP_CYCLES - 1);
                if (state == SH_CLKLO)
                    dat_q <= frame_q[bit_idx];
                if (state == SH_CLKHI) begin
                    if (bit_idx == '0)
                        dat_q <= 1'b1;
                    else
                        bit_idx <= bit_idx - 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        done  = (state == SH_END) && step_end;
        sdout = dat_q;
        sclk  = !(state == SH_CLKLO || state == SH_DATA);
        if (state == SH_SEL || state == SH_CLKLO || state == SH_DATA || state == SH_CLKHI)
            cs_n = sel_q ? 2'b01 : 2'b10;
        else
            cs_n = 2'b11;
    end

    // R11
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && cs_n != 2'b11 && $past(cs_n) != 2'b11) |-> $stable(sdout));

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_IDLE) |-> (cs_n == 2'b11 && sclk && sdout));

    // R5
    release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) != 2'b11 && cs_n == 2'b11) |-> (sdout && sclk));
endmodule

// File: rtl/cwe_codec_ctl.sv
module cwe_codec_ctl
    import cwe_pkg::*;
#(
    parameter int STEP_CYCLES = 16,
    parameter int RATE_W      = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [2:0]        req_chip,
    input  logic [4:0]        req_addr,
    input  logic [7:0]        req_data,
    input  logic [7:0]        req_mask,
    input  logic [RATE_W-1:0] req_rate,
    output logic              busy,
    output logic [1:0]        cs_n,
    output logic              sclk,
    output logic              sdout
);
    localparam int REGS = 1 << ADDR_W;

    ctl_state_e          state;
    logic                bcast_q;
    logic [CHIP_W-1:0]   chip_q;
    logic [CHIP_W-1:0]   idx_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          val_q;
    logic [7:0]          mask_q;
    logic [7:0]          shadow [CHIPS][REGS];

    logic [7:0]          speed_bits;
    logic                rate_nz;
    logic                accept;
    logic                ser_start, ser_done;
    logic [CHIP_W-1:0]   launch_chip;
    logic [7:0]          launch_byte;
    cwe_op_e             op;

    assign op     = cwe_op_e'(req_op);
    assign accept = req_valid && req_ready;

    cwe_rate_map #(.RATE_W(RATE_W)) i_rate_map (
        .rate       (req_rate),
        .speed_bits (speed_bits),
        .rate_valid (rate_nz)
    );

    always_comb begin
        launch_chip = bcast_q ? idx_q : chip_q;
        launch_byte = bcast_q ? ((shadow[idx_q][addr_q] & ~mask_q) | val_q) : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CT_IDLE;
            bcast_q <= 1'b0;
            chip_q  <= '0;
            idx_q   <= '0;
            addr_q  <= '0;
            val_q   <= '0;
            mask_q  <= '0;
            for (int c = 0; c < CHIPS; c++)
                for (int r = 0; r < REGS; r++)
                    shadow[c][r] <= '0;
        end else begin
            unique case (state)
                CT_IDLE: if (accept) begin
                    idx_q <= '0;
                    unique case (op)
                        OP_WRITE: if (req_chip <= 3'd3) begin
                            bcast_q <= 1'b0;
                            chip_q  <= CHIP_W'(req_chip != 3'd0);
                            addr_q  <= req_addr;
                            val_q   <= req_data;
                            state   <= CT_LAUNCH;
                        end
                        OP_BCAST: begin
                            bcast_q <= 1'b1;
                            addr_q  <= req_addr;
                            val_q   <= req_data;
                            mask_q  <= req_mask;
                            state   <= CT_LAUNCH;
                        end
                        OP_RATE: if (rate_nz) begin
                            bcast_q <= 1'b1;
                            addr_q  <= SPEED_REG;
                            val_q   <= speed_bits;
                            mask_q  <= SPEED_MASK;
                            state   <= CT_LAUNCH;
                        end
                        OP_NONE: ;
                        default: ;
                    endcase
                end
                CT_LAUNCH: begin
                    shadow[launch_chip][addr_q] <= launch_byte;
                    state <= CT_WAIT;
                end
                CT_WAIT: if (ser_done) begin
                    if (bcast_q && idx_q != CHIP_W'(CHIPS - 1)) begin
                        idx_q <= idx_q + 1'b1;
                        state <= CT_LAUNCH;
                    end else begin
                        state <= CT_IDLE;
                    end
                end
                default: state <= CT_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == CT_IDLE);
        busy      = (state != CT_IDLE);
        ser_start = (state == CT_LAUNCH);
    end

    cwe_shifter #(.STEP_CYCLES(STEP_CYCLES)) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ser_start),
        .chip_sel (launch_chip != '0),
        .frame    (build_frame(addr_q, launch_byte)),
        .done     (ser_done),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdout    (sdout)
    );

    // R10
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n == 2'b11));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R6
    bcast_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcast_q && $fell(cs_n[1])) |-> (idx_q == CHIP_W'(1)));
endmodule

// File: tb/test_cwe_codec_ctl.sv
module test_cwe_codec_ctl;
    localparam int STEP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_chip = '0;
    logic [4:0]  req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [7:0]  req_mask = '0;
    logic [17:0] req_rate = '0;
    logic        busy;
    logic [1:0]  cs_n;
    logic        sclk, sdout;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cwe_codec_ctl #(.STEP_CYCLES(STEP), .RATE_W(18)) i_cwe_codec_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_chip(req_chip), .req_addr(req_addr),
        .req_data(req_data), .req_mask(req_mask), .req_rate(req_rate),
        .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdout(sdout)
    );

    logic [15:0] fr_val[$];
    int          fr_cs[$];
    int          fr_bits[$];
    int          fr_len[$];
    logic [15:0] ex_val[$];
    int          ex_cs[$];
    logic [7:0]  mdl [2][32];

    logic [1:0]  p_cs = 2'b11;
    logic        p_sclk = 1'b1, p_sdout = 1'b1;
    logic [15:0] shv = '0;
    int          nbits = 0, nlen = 0, hold_bad = 0, both_low = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n == 2'b00) both_low++;
            if (cs_n != 2'b11) begin
                nlen++;
                if (sclk && !p_sclk) begin
                    shv = {shv[14:0], sdout};
                    nbits++;
                end
                if (sclk && p_sclk && p_cs != 2'b11 && sdout != p_sdout) hold_bad++;
            end
            if (p_cs != 2'b11 && cs_n == 2'b11) begin
                fr_val.push_back(shv);
                fr_cs.push_back(p_cs == 2'b10 ? 0 : 1);
                fr_bits.push_back(nbits);
                fr_len.push_back(nlen);
                if (!(sdout && sclk)) hold_bad++;
                nbits = 0; nlen = 0; shv = '0;
            end
            p_cs = cs_n; p_sclk = sclk; p_sdout = sdout;
        end
    end

    function automatic logic [7:0] speed_of(input int r);
        if (r > 108000) return 8'h0A;
        if (r > 54000)  return 8'h05;
        return 8'h00;
    endfunction

    function automatic logic [15:0] mk(input logic [4:0] a, input logic [7:0] d);
        return {2'b10, 1'b1, a, d};
    endfunction

    task automatic model_bcast(input logic [4:0] a, input logic [7:0] m, input logic [7:0] v);
        for (int c = 0; c < 2; c++) begin
            logic [7:0] nv;
            nv = (mdl[c][a] & ~m) | v;
            mdl[c][a] = nv;
            ex_val.push_back(mk(a, nv));
            ex_cs.push_back(c);
        end
    endtask

    task automatic do_req(input int op, input int chip, input int a, input int d,
                          input int m, input int r, input string tag, input bit spam);
        bit active;
        active = 0;
        case (op)
            0: if (chip <= 3) begin
                   active = 1;
                   mdl[chip != 0][a] = 8'(d);
                   ex_val.push_back(mk(5'(a), 8'(d)));
                   ex_cs.push_back(chip != 0);
               end
            1: begin active = 1; model_bcast(5'(a), 8'(m), 8'(d)); end
            2: if (r != 0) begin active = 1; model_bcast(5'h02, 8'h0F, speed_of(r)); end
            default: ;
        endcase
        while (!req_ready) @(negedge clk);
        req_op = 2'(op); req_chip = 3'(chip); req_addr = 5'(a);
        req_data = 8'(d); req_mask = 8'(m); req_rate = 18'(r);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (active) begin
            chk(busy && !req_ready, "R10 busy after accept", {busy, req_ready}, 2'b10);
            if (spam) begin
                req_op = 2'd0; req_chip = 3'd0; req_addr = 5'h1F; req_data = 8'hEE;
                req_valid = 1'b1;
            end
        end else begin
            chk(!busy && req_ready, {tag, " no activity"}, {busy, req_ready}, 2'b01);
        end
        while (busy) @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(fr_val.size() == ex_val.size(), {tag, " frame count"}, fr_val.size(), ex_val.size());
        while (fr_val.size() > 0 && ex_val.size() > 0) begin
            logic [15:0] gv, ev;
            int gc, ec, gb, gl;
            gv = fr_val.pop_front(); ev = ex_val.pop_front();
            gc = fr_cs.pop_front();  ec = ex_cs.pop_front();
            gb = fr_bits.pop_front(); gl = fr_len.pop_front();
            chk(gv == ev, {tag, " R2 frame"}, gv, ev);
            chk(gc == ec, {tag, " R3 select"}, gc, ec);
            chk(gb == 16, "R2 bit count", gb, 16);
            chk(gl == 49 * STEP, "R5 select width", gl, 49 * STEP);
        end
        fr_val.delete(); fr_cs.delete(); fr_bits.delete(); fr_len.delete();
        ex_val.delete(); ex_cs.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 32; r++)
                mdl[c][r] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 2'b11 && sclk && sdout, "R1 idle lines", {cs_n, sclk, sdout}, 4'hF);
        chk(req_ready && !busy, "R1 ready after reset", {req_ready, busy}, 2'b10);

        // R3 direct write to each select, and rejected indices
        do_req(0, 0, 5'h03, 8'hA5, 0, 0, "R3 chip0", 0);
        do_req(0, 2, 5'h11, 8'h5A, 0, 0, "R3 chip2", 0);
        do_req(0, 4, 5'h03, 8'hFF, 0, 0, "R3 chip4", 0);
        do_req(0, 7, 5'h04, 8'h01, 0, 0, "R3 chip7", 0);
        do_req(3, 0, 5'h04, 8'h01, 0, 0, "R3 op3", 0);
        // R7 shadow observed through a neutral broadcast
        do_req(1, 0, 5'h03, 8'h00, 8'h00, 0, "R7 shadow echo", 0);
        // R6 masked merge
        do_req(1, 0, 5'h11, 8'h81, 8'hC3, 0, "R6 merge", 0);
        // R8 / R9 rate thresholds
        do_req(2, 0, 0, 0, 0, 44100,  "R8 rate 44100", 0);
        do_req(2, 0, 0, 0, 0, 54000,  "R8 rate 54000", 0);
        do_req(2, 0, 0, 0, 0, 54001,  "R8 rate 54001", 0);
        do_req(2, 0, 0, 0, 0, 108000, "R8 rate 108000", 0);
        do_req(2, 0, 0, 0, 0, 108001, "R8 rate 108001", 0);
        do_req(2, 0, 0, 0, 0, 192000, "R8 rate 192000", 0);
        do_req(2, 0, 0, 0, 0, 0,      "R9 rate zero", 0);
        // R10 request held off while busy
        do_req(0, 1, 5'h08, 8'h3C, 0, 0, "R10 hold off", 1);

        for (int i = 0; i < 50; i++) begin
            int op, r;
            op = int'($urandom_range(0, 3));
            r  = (($urandom_range(0, 4)) == 0) ? 0 : int'($urandom_range(1, 200000));
            do_req(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 31)),
                   int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), r,
                   "R6 R7 random", 0);
        end

        chk(hold_bad == 0, "R4 data stable while clock high", hold_bad, 0);
        chk(both_low == 0, "R11 single select", both_low, 0);
        chk(cs_n == 2'b11 && sclk && sdout, "R1 idle at end", {cs_n, sclk, sdout}, 4'hF);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule